// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block captures hardware configuration straps at two distinct power-up events and presents them as steady configuration outputs for the rest of operation. Two straps follow the monitored chip reset: an active-low output-float strap and a self-test enable. Both are taken on the cycle in which the active-low reset input is seen to release. A second group is taken on the cycle in which the power-good input is seen to rise: six boot-mode flags and a two-bit socket number.

A latched value changes only on a new qualifying edge of its own event signal. Strap toggles at any other time are ignored. When the output-float strap is taken low, the block raises a package-wide output tri-state request, which serves fault-resilient boot. A separate firmware-writable mask, one bit per core, disables individual cores without floating the whole package. Dropping power-good clears every latched output and the mask.

All inputs are synchronous to `clk` and are sampled on its rising edge. A one-cycle valid pulse marks every fresh capture.

Top module: `strap_sampler`

## Requirements
- R1: While `rst` is high, every output is 0 on the following clock.
- R2: On the cycle where `sys_rst_n` is 1 after being 0 on the previous clock, with `pwr_ok` high, `out_hiz` becomes the inverse of `strap_hiz_n` (strap low means tri-state requested). The new value is visible after that clock edge.
- R3: `selftest_req` is captured from `strap_selftest` on that same reset-release event.
- R4: On the cycle where `pwr_ok` is 1 after being 0, `boot_flags_o` takes `strap_boot_flags` and `sock_id_o` takes the 2-bit `strap_sock_id`. The flag bits are: 0 service-processor boot, 1 trusted platform enable, 2 power-up sequence halt, 3 firmware agent, 4 trusted agent, 5 safe-mode boot.
- R5: Outside its own latching event, each latched output holds its value whatever its strap input does.
- R6: While `pwr_ok` is low, `out_hiz`, `selftest_req`, `boot_flags_o`, `sock_id_o` and `cd_rdata` are 0 after the next clock. This holds even if a reset release is seen at the same time.
- R7: With `pwr_ok` high, `cd_we` high loads `cd_wdata` into the core disable mask, which reads back on `cd_rdata` after the clock. With `cd_we` low, or with `pwr_ok` low, a write has no effect.
- R8: `cfg_valid` is high for one cycle after each latching event: either a reset release with `pwr_ok` high, or a power-good rise. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_n | input | 1 | Monitored chip reset, active low |
| pwr_ok | input | 1 | Monitored power-good, active high |
| strap_hiz_n | input | 1 | Output-float strap, active low |
| strap_selftest | input | 1 | Self-test enable strap |
| strap_boot_flags | input | 6 | Boot-mode flag straps |
| strap_sock_id | input | 2 | Socket number straps |
| cd_we | input | 1 | Core disable mask write enable |
| cd_wdata | input | 4 | Core disable mask write data |
| out_hiz | output | 1 | Package-wide output tri-state request |
| selftest_req | output | 1 | Self-test request |
| boot_flags_o | output | 6 | Latched boot-mode flags |
| sock_id_o | output | 2 | Latched socket number |
| cd_rdata | output | 4 | Core disable mask read-back |
| cfg_valid | output | 1 | One-cycle pulse after a capture |

## Verification
Every result of this block is due on the first rising clock edge after the stimulus that causes it. This covers captures, clears, mask writes and the valid pulse. The bench drives inputs on the falling edge and pushes the expected output word for that stimulus into a queue. A monitor pops one entry 5 ns after each following rising edge and compares it, so each expectation meets exactly the edge that should produce it. The sequence covers drops of power-good that override a reset release, and writes made while power-good is low.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int N_BOOT_FLAGS_DEF = 6;
  localparam int SOCK_ID_W_DEF    = 2;
  localparam int N_CORES_DEF      = 4;
  // boot flag bit positions
  localparam int FLG_SVC_BOOT   = 0;
  localparam int FLG_TRUST_PLAT = 1;
  localparam int FLG_SEQ_HALT   = 2;
  localparam int FLG_FW_AGENT   = 3;
  localparam int FLG_TRUST_AGT  = 4;
  localparam int FLG_SAFE_BOOT  = 5;
endpackage

// File: rtl/edge_det.sv
module edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= '0;
    else     d_q <= d;
  end

  always_comb rise = d & ~d_q;
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= d;
  end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int N_BOOT_FLAGS = N_BOOT_FLAGS_DEF,
  parameter int SOCK_ID_W    = SOCK_ID_W_DEF,
  parameter int N_CORES      = N_CORES_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sys_rst_n,
  input  logic                    pwr_ok,
  input  logic                    strap_hiz_n,
  input  logic                    strap_selftest,
  input  logic [N_BOOT_FLAGS-1:0] strap_boot_flags,
  input  logic [SOCK_ID_W-1:0]    strap_sock_id,
  input  logic                    cd_we,
  input  logic [N_CORES-1:0]      cd_wdata,
  output logic                    out_hiz,
  output logic                    selftest_req,
  output logic [N_BOOT_FLAGS-1:0] boot_flags_o,
  output logic [SOCK_ID_W-1:0]    sock_id_o,
  output logic [N_CORES-1:0]      cd_rdata,
  output logic                    cfg_valid
);
  localparam int PG_W = N_BOOT_FLAGS + SOCK_ID_W;

  logic [1:0] rises;
  logic       rst_rel, pg_rise, pg_lost;

  edge_det #(.W(2)) u_edges (
    .clk (clk),
    .rst (rst),
    .d   ({pwr_ok, sys_rst_n}),
    .rise(rises)
  );

  assign rst_rel = rises[0];
  assign pg_rise = rises[1];
  assign pg_lost = ~pwr_ok;

  // reset-release group: float request is taken from an active-low strap
  strap_latch #(.W(2)) u_rst_grp (
    .clk (clk),
    .rst (rst),
    .clr (pg_lost),
    .load(rst_rel),
    .d   ({~strap_hiz_n, strap_selftest}),
    .q   ({out_hiz, selftest_req})
  );

  // power-good group
  strap_latch #(.W(PG_W)) u_pg_grp (
    .clk (clk),
    .rst (rst),
    .clr (pg_lost),
    .load(pg_rise),
    .d   ({strap_sock_id, strap_boot_flags}),
    .q   ({sock_id_o, boot_flags_o})
  );

  // firmware core disable mask
  strap_latch #(.W(N_CORES)) u_core_mask (
    .clk (clk),
    .rst (rst),
    .clr (pg_lost),
    .load(cd_we),
    .d   (cd_wdata),
    .q   (cd_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_valid <= 1'b0;
    else     cfg_valid <= pg_rise | (rst_rel & pwr_ok);
  end

  // ---------------- assertions ----------------
  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (cfg_valid == 1'b0 && cd_rdata == '0 && sock_id_o == '0));

  p_hiz_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (rst_rel && pwr_ok) |=> (out_hiz == !$past(strap_hiz_n)));

  p_selftest_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (rst_rel && pwr_ok) |=> (selftest_req == $past(strap_selftest)));

  p_sock_capture_r4: assert property (@(posedge clk) disable iff (rst)
    pg_rise |=> (sock_id_o == $past(strap_sock_id) &&
                 boot_flags_o == $past(strap_boot_flags)));

  p_pg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!pg_rise && pwr_ok) |=> $stable(sock_id_o));

  p_pg_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (!out_hiz && !selftest_req && boot_flags_o == '0 &&
                 sock_id_o == '0 && cd_rdata == '0));

  p_mask_write_r7: assert property (@(posedge clk) disable iff (rst)
    (cd_we && pwr_ok) |=> (cd_rdata == $past(cd_wdata)));

  p_valid_cause_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> $past(pg_rise || (rst_rel && pwr_ok)));
endmodule

// File: tb/test_strap_sampler.sv
module test_strap_sampler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_rst_n = 1'b0;
  logic       pwr_ok = 1'b0;
  logic       strap_hiz_n = 1'b1;
  logic       strap_selftest = 1'b0;
  logic [5:0] strap_boot_flags = '0;
  logic [1:0] strap_sock_id = '0;
  logic       cd_we = 1'b0;
  logic [3:0] cd_wdata = '0;
  logic       out_hiz, selftest_req, cfg_valid;
  logic [5:0] boot_flags_o;
  logic [1:0] sock_id_o;
  logic [3:0] cd_rdata;

  always #10 clk = ~clk; // 50 MHz

  strap_sampler i_strap_sampler (
    .clk(clk), .rst(rst), .sys_rst_n(sys_rst_n), .pwr_ok(pwr_ok),
    .strap_hiz_n(strap_hiz_n), .strap_selftest(strap_selftest),
    .strap_boot_flags(strap_boot_flags), .strap_sock_id(strap_sock_id),
    .cd_we(cd_we), .cd_wdata(cd_wdata),
    .out_hiz(out_hiz), .selftest_req(selftest_req),
    .boot_flags_o(boot_flags_o), .sock_id_o(sock_id_o),
    .cd_rdata(cd_rdata), .cfg_valid(cfg_valid)
  );

  typedef struct {
    logic [14:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic       m_hiz = 0, m_st = 0, m_valid = 0, m_prev_rn = 0, m_prev_pg = 0;
  logic [5:0] m_fl = '0;
  logic [1:0] m_sk = '0;
  logic [3:0] m_mask = '0;

  task automatic step(input logic r, input logic rn, input logic pg,
                      input logic hn, input logic st, input logic [5:0] fl,
                      input logic [1:0] sk, input logic we, input logic [3:0] wd,
                      input string tag);
    logic rr, pr;
    item_t it;
    @(negedge clk);
    rst = r; sys_rst_n = rn; pwr_ok = pg; strap_hiz_n = hn;
    strap_selftest = st; strap_boot_flags = fl; strap_sock_id = sk;
    cd_we = we; cd_wdata = wd;
    if (r) begin
      m_hiz = 0; m_st = 0; m_fl = '0; m_sk = '0; m_mask = '0; m_valid = 0;
      m_prev_rn = 0; m_prev_pg = 0;
    end else begin
      rr = rn && !m_prev_rn;
      pr = pg && !m_prev_pg;
      m_valid = (rr && pg) || pr;
      if (!pg) begin
        m_hiz = 0; m_st = 0; m_fl = '0; m_sk = '0; m_mask = '0;
      end else begin
        if (rr) begin m_hiz = !hn; m_st = st; end
        if (pr) begin m_fl = fl; m_sk = sk; end
        if (we) m_mask = wd;
      end
      m_prev_rn = rn; m_prev_pg = pg;
    end
    it.exp = {m_valid, m_hiz, m_st, m_fl, m_sk, m_mask};
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        logic [14:0] act;
        it  = sb.pop_front();
        act = {cfg_valid, out_hiz, selftest_req, boot_flags_o, sock_id_o, cd_rdata};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    //   rst rn pg hn st flags      sk     we wd
    step(1, 0, 0, 1, 0, 6'b000000, 2'b00, 0, 4'h0, "R1 reset");
    step(1, 0, 1, 0, 1, 6'b111111, 2'b11, 1, 4'hF, "R1 reset ignores inputs");
    step(0, 0, 0, 0, 1, 6'b110011, 2'b11, 1, 4'h5, "R6 pg low zeros and R7 write ignored");
    step(0, 0, 1, 1, 0, 6'b101101, 2'b10, 0, 4'h0, "R4 pg rise capture R8 valid");
    step(0, 0, 1, 0, 1, 6'b010010, 2'b01, 0, 4'h0, "R5 pg straps ignored R8 no valid");
    step(0, 1, 1, 0, 1, 6'b000000, 2'b00, 0, 4'h0, "R2 R3 reset release capture R8");
    step(0, 1, 1, 1, 0, 6'b111111, 2'b11, 0, 4'h0, "R5 reset straps ignored");
    step(0, 1, 1, 1, 0, 6'b111111, 2'b11, 1, 4'hA, "R7 mask write");
    step(0, 1, 1, 1, 0, 6'b111111, 2'b11, 0, 4'h3, "R7 no write with we low");
    step(0, 0, 1, 1, 1, 6'b000000, 2'b00, 0, 4'h0, "R5 reset assert holds values");
    step(0, 1, 1, 1, 0, 6'b000000, 2'b00, 0, 4'h0, "R2 release with strap high no hiz");
    step(0, 1, 1, 0, 1, 6'b000000, 2'b00, 1, 4'h6, "R7 second mask write");
    step(0, 1, 0, 0, 1, 6'b111111, 2'b11, 0, 4'h0, "R6 pg drop clears all");
    step(0, 0, 0, 0, 1, 6'b111111, 2'b11, 0, 4'h0, "R6 pg low");
    step(0, 1, 0, 0, 1, 6'b111111, 2'b11, 1, 4'h9, "R6 release while pg low ignored");
    step(0, 1, 1, 0, 1, 6'b100001, 2'b01, 0, 4'h0, "R4 pg rise second capture");
    step(0, 1, 1, 0, 1, 6'b011110, 2'b10, 0, 4'h0, "R5 hold after second capture");
    step(0, 0, 1, 0, 1, 6'b011110, 2'b10, 0, 4'h0, "R8 no valid on reset assert");
    step(0, 1, 1, 0, 0, 6'b011110, 2'b10, 0, 4'h0, "R2 R3 capture hiz set selftest clear");
    step(0, 0, 0, 1, 1, 6'b000000, 2'b00, 0, 4'h0, "R6 both low");
    step(0, 1, 1, 0, 1, 6'b110110, 2'b11, 0, 4'h0, "R8 simultaneous edges R2 R4");
    step(0, 1, 1, 1, 0, 6'b000000, 2'b00, 0, 4'h0, "R5 final hold");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule